// File: doc/BRIEF.md
# Standard Event Status Register

This block holds the eight-bit register of standard events in an instrument's status reporting tree. It has no condition register and no transition filters. Each event source drives a one-cycle pulse, and that pulse sets a fixed bit in the register. A set bit stays set until the host reads the register or issues a global clear. The power-on bit is set by the block itself in the first cycle after reset is released.

A host-writable enable mask selects which latched events drive the summary output. The summary output feeds bit 5 of the status byte. The mask can be read back. A level input chooses whether a reset clears the mask or leaves it unchanged. Sorting error numbers into the four error classes is done by the host before it pulses the matching input.

Top module: `event_status_latch`

## Requirements
- R1: Event pulses set fixed bit positions: `evt_opdone` sets bit 0, `evt_query` sets bit 2, `evt_device` sets bit 3, `evt_exec` sets bit 4, `evt_command` sets bit 5 and `evt_local` sets bit 6. Each bit is visible on `rd_data` one clock after its pulse. No input gates the local key event.
- R2: Bit 1 of `rd_data` is 0 at all times.
- R3: `rd_data` always shows the register contents. A cycle with `rd_stb` high clears the register at the next clock edge.
- R4: A cycle with `clear_all` high empties the register at the next clock edge.
- R5: An event pulse that arrives in the same cycle as `rd_stb` or `clear_all` is held in the register after that edge.
- R6: `summary` is high exactly when some bit is set in both `rd_data` and `mask_rdata`.
- R7: Bit 7 (power-on) is set at the first clock edge after `rst_n` is released. It is 0 while reset is held.
- R8: A cycle with `mask_we` high loads all eight bits of `mask_wdata` into the mask, and the mask shows on `mask_rdata` from the next cycle.
- R9: A reset with `clr_on_reset` high clears the mask. A reset with `clr_on_reset` low leaves the mask unchanged.
- R10: Latched bits do not fall in a cycle with neither `rd_stb` nor `clear_all` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr_on_reset | input | 1 | When high, reset also clears the enable mask |
| evt_opdone | input | 1 | Pulse: pending operations completed |
| evt_query | input | 1 | Pulse: query error |
| evt_device | input | 1 | Pulse: device-dependent error |
| evt_exec | input | 1 | Pulse: execution error |
| evt_command | input | 1 | Pulse: command error |
| evt_local | input | 1 | Pulse: local key pressed |
| clear_all | input | 1 | Global clear of the event register |
| rd_stb | input | 1 | Read strobe; the register clears after this cycle |
| rd_data | output | 8 | Current event register contents |
| mask_we | input | 1 | Enable mask write strobe |
| mask_wdata | input | 8 | Enable mask write value |
| mask_rdata | output | 8 | Current enable mask |
| summary | output | 1 | OR of register AND mask, to status byte bit 5 |

## Verification
The assertions assume that a reset with `clr_on_reset` high comes before any check that uses the mask. Until then the mask holds no defined value. They also assume that the only time the block sets bits by itself is the edge right after reset is released. The stimulus does this: the first reset holds `clr_on_reset` high, and the read-clear property is only checked away from a reset release. Every input is changed just after a rising edge, so each pulse is sampled by exactly one edge.

// File: rtl/event_status_latch.sv
module event_status_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_on_reset,
  input  logic       evt_opdone,
  input  logic       evt_query,
  input  logic       evt_device,
  input  logic       evt_exec,
  input  logic       evt_command,
  input  logic       evt_local,
  input  logic       clear_all,
  input  logic       rd_stb,
  output logic [7:0] rd_data,
  input  logic       mask_we,
  input  logic [7:0] mask_wdata,
  output logic [7:0] mask_rdata,
  output logic       summary
);

  logic [7:0] ev_q;
  logic [7:0] mask_q;
  logic       boot_q;

  // bit 1 is never set; bit 7 only by the reset release
  wire [7:0] set_v = {boot_q, evt_local, evt_command, evt_exec,
                      evt_device, evt_query, 1'b0, evt_opdone};
  wire       wipe  = rd_stb | clear_all;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_q   <= '0;
      boot_q <= 1'b1;
      if (clr_on_reset) mask_q <= '0;
    end else begin
      boot_q <= 1'b0;
      ev_q   <= (wipe ? 8'h00 : ev_q) | set_v;
      if (mask_we) mask_q <= mask_wdata;
    end
  end

  assign rd_data    = ev_q;
  assign mask_rdata = mask_q;
  assign summary    = |(ev_q & mask_q);

endmodule

// File: rtl/event_status_latch_chk.sv
module event_status_latch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       evt_opdone,
  input logic       evt_query,
  input logic       evt_device,
  input logic       evt_exec,
  input logic       evt_command,
  input logic       evt_local,
  input logic       clear_all,
  input logic       rd_stb,
  input logic [7:0] rd_data,
  input logic       mask_we,
  input logic [7:0] mask_wdata,
  input logic [7:0] mask_rdata,
  input logic       summary
);

  wire any_evt = evt_opdone | evt_query | evt_device | evt_exec | evt_command | evt_local;

  p_bit1_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[1] == 1'b0);

  p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !any_evt && $past(rst_n)) |=> rd_data == 8'h00);

  p_clear_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_all && !any_evt && $past(rst_n)) |=> rd_data == 8'h00);

  p_cmd_survives_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_command && (rd_stb || clear_all)) |=> rd_data[5]);

  p_summary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    summary == ((rd_data & mask_rdata) != 8'h00));

  p_power_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |=> rd_data[7]);

  p_mask_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> mask_rdata == $past(mask_wdata));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && !clear_all) |=> (rd_data & $past(rd_data)) == $past(rd_data));

  p_opdone_r1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_opdone |=> rd_data[0]);

endmodule

bind event_status_latch event_status_latch_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .evt_opdone(evt_opdone), .evt_query(evt_query), .evt_device(evt_device),
  .evt_exec(evt_exec), .evt_command(evt_command), .evt_local(evt_local),
  .clear_all(clear_all), .rd_stb(rd_stb), .rd_data(rd_data),
  .mask_we(mask_we), .mask_wdata(mask_wdata), .mask_rdata(mask_rdata),
  .summary(summary)
);

// File: tb/event_status_latch_bench.sv
`timescale 1ns/1ps
module event_status_latch_bench;
  logic clk = 1'b0;
  logic rst_n, clr_on_reset;
  logic evt_opdone, evt_query, evt_device, evt_exec, evt_command, evt_local;
  logic clear_all, rd_stb, mask_we;
  logic [7:0] mask_wdata, rd_data, mask_rdata;
  logic summary;
  int n_run = 0, n_fail = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  event_status_latch u_event_status_latch (
    .clk(clk), .rst_n(rst_n), .clr_on_reset(clr_on_reset),
    .evt_opdone(evt_opdone), .evt_query(evt_query), .evt_device(evt_device),
    .evt_exec(evt_exec), .evt_command(evt_command), .evt_local(evt_local),
    .clear_all(clear_all), .rd_stb(rd_stb), .rd_data(rd_data),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .mask_rdata(mask_rdata),
    .summary(summary)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // p bits: 0 opdone, 1 query, 2 device, 3 exec, 4 command, 5 local
  function automatic logic [7:0] map_bits(logic [5:0] p);
    return {1'b0, p[5], p[4], p[3], p[2], p[1], 1'b0, p[0]};
  endfunction

  task automatic drive_evt(logic [5:0] p);
    {evt_local, evt_command, evt_exec, evt_device, evt_query, evt_opdone} = p;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr_on_reset = 1'b1; drive_evt(6'h0);
    clear_all = 1'b0; rd_stb = 1'b0; mask_we = 1'b0; mask_wdata = 8'h00;
    tick(); tick(); tick();
    chk8("R7 reset", rd_data, 8'h00);
    chk8("R9 reset clears mask", mask_rdata, 8'h00);
    rst_n = 1'b1;
    tick();
    chk8("R7 power-on bit", rd_data, 8'h80);
    rd_stb = 1'b1;
    chk8("R3 read value", rd_data, 8'h80);
    tick(); rd_stb = 1'b0;
    chk8("R3 cleared by read", rd_data, 8'h00);

    for (int p = 0; p < 64; p++) begin
      logic [7:0] e;
      e = map_bits(6'(p));
      drive_evt(6'(p)); tick(); drive_evt(6'h0);
      chk8("R1 event map", rd_data, e);
      chk8("R2 bit1 low", {7'b0, rd_data[1]}, 8'h00);
      for (int m = 0; m < 256; m++) begin
        mask_we = 1'b1; mask_wdata = 8'(m); tick();
        chk8("R8 mask readback", mask_rdata, 8'(m));
        chk8("R6 summary", {7'b0, summary}, {7'b0, (e & 8'(m)) != 8'h00});
      end
      mask_we = 1'b0;
      chk8("R10 held while idle", rd_data, e);
      rd_stb = 1'b1; tick(); rd_stb = 1'b0;
      chk8("R3 read clears", rd_data, 8'h00);
    end

    drive_evt(6'h01); tick();
    rd_stb = 1'b1; drive_evt(6'h3F); tick(); rd_stb = 1'b0; drive_evt(6'h0);
    chk8("R5 pulses with read", rd_data, 8'h7D);
    clear_all = 1'b1; drive_evt(6'h01); tick(); clear_all = 1'b0; drive_evt(6'h0);
    chk8("R5 pulse with clear", rd_data, 8'h01);
    clear_all = 1'b1; tick(); clear_all = 1'b0;
    chk8("R4 global clear", rd_data, 8'h00);

    mask_we = 1'b1; mask_wdata = 8'hA5; tick(); mask_we = 1'b0;
    clr_on_reset = 1'b0; rst_n = 1'b0; tick(); tick();
    chk8("R9 mask kept", mask_rdata, 8'hA5);
    rst_n = 1'b1; tick();
    chk8("R7 power-on after soft reset", rd_data, 8'h80);
    chk8("R6 summary power bit masked", {7'b0, summary}, 8'h01);
    clr_on_reset = 1'b1; rst_n = 1'b0; tick();
    chk8("R9 mask cleared", mask_rdata, 8'h00);
    rst_n = 1'b1; tick();
    chk8("R6 summary with empty mask", {7'b0, summary}, 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule